// File: doc/BRIEF.md
# Packed 4:2:2 Word-to-Byte Video Serializer

The block takes 32-bit words, each carrying two horizontally adjacent 4:2:2 pixels (two luma samples sharing one blue-difference and one red-difference chroma sample). It turns them into an 8-bit byte stream for a BT.656-style video port. The port uses eight data lines and one pixel clock, nominally 27 MHz. The components may sit in the word in any of eight layouts, picked by a 3-bit layout code. A byte-swap flag can reverse the four bytes before the layout is decoded. Whatever the input layout, the output always carries Cb, Y0, Cr, Y1, one byte per clock.

Words arrive over a valid/ready handshake. The block asks for a new word only when it is idle and enabled, or in the cycle that carries the last byte of the current word. If no word is offered at that point, the block fills the slot with a blank pixel pair and raises a one-cycle underrun flag. The layout code and the swap flag are captured together with the word, so a change to either one during a word only affects the next word.

The control is a five-state machine. `S_IDLE` means no output. `S_CB`, `S_Y0`, `S_CR` and `S_Y1` each drive one component byte. The transitions are:
- idle-start: `S_IDLE` to `S_CB` when enabled.
- step: `S_CB` to `S_Y0` to `S_CR` to `S_Y1`, always taken.
- wrap: `S_Y1` to `S_CB` when enabled.
- stop: `S_Y1` or `S_IDLE` goes to (or stays in) `S_IDLE` when not enabled.

Top module: `ycc422_serializer`

## Requirements
- R1: While reset is held and after it is released with `enable` low, `out_valid`, `underrun` and `in_ready` are all 0.
- R2: With `big_endian`=0, the word is read as bytes b3 (bits 31:24) down to b0 (bits 7:0). Each layout code names the component in b3, b2, b1, b0, in that order:
  - 0 = Cb Y0 Cr Y1
  - 1 = Y0 Cb Y1 Cr
  - 2 = Cr Y0 Cb Y1
  - 3 = Y1 Cb Y0 Cr
  - 4 = Cr Y1 Cb Y0
  - 5 = Y1 Cr Y0 Cb
  - 6 = Cb Y1 Cr Y0
  - 7 = Y0 Cr Y1 Cb
- R3: With `big_endian`=1, the four bytes are reversed (bits 7:0 become b3) before the R2 layout is applied.
- R4: After a word is accepted, the next four cycles show its Cb, Y0, Cr and Y1 bytes in that order with `out_valid`=1. While `enable` stays high there is no gap between words.
- R5: `in_ready` is 1 exactly when `enable` is 1 and the machine is in `S_IDLE` or `S_Y1`. A word is accepted on a clock edge where both `in_valid` and `in_ready` are 1.
- R6: `ord_code`, `big_endian` and `in_data` are sampled only at acceptance. Changes made during the remaining bytes of a word do not alter that word's output.
- R7: When `in_ready` is 1 but `in_valid` is 0, the next four bytes are 0x80, 0x10, 0x80, 0x10, and `underrun` is 1 for exactly the cycle that shows the first 0x80.
- R8: Dropping `enable` in the middle of a word does not cut the word short. If `enable` is low in the `S_Y1` cycle, the machine returns to `S_IDLE` and `out_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| enable | input | 1 | run request, checked at word boundaries |
| ord_code | input | 3 | component layout code |
| big_endian | input | 1 | reverse word bytes before decoding |
| in_data | input | 32 | packed two-pixel word |
| in_valid | input | 1 | word offered |
| in_ready | output | 1 | word can be taken this cycle |
| out_byte | output | 8 | serialized component byte |
| out_valid | output | 1 | `out_byte` carries a component |
| underrun | output | 1 | a blank pair replaced a missing word |

## Verification
The assertions assume that every input has a known value on each rising edge after reset. They do not require `in_valid` to be held once raised, because the block looks at it only while `in_ready` is high. The bench changes all inputs on the falling edge. In the cycles where `in_ready` is low, it deliberately puts scrambled layout codes, swap flags and data on the inputs. It then sweeps every layout code with both swap settings, inserts missing words, and drops `enable` both in the middle of a word and at a word boundary.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CB,
        S_Y0,
        S_CR,
        S_Y1
    } ser_state_t;

    // Component indices inside a held pixel pair; emission runs high to low.
    localparam int COMP_CB = 3;
    localparam int COMP_Y0 = 2;
    localparam int COMP_CR = 1;
    localparam int COMP_Y1 = 0;

    // Byte slot (3 = most significant) for each component, packed {Cb,Y0,Cr,Y1}.
    function automatic logic [7:0] slot_map(input logic [2:0] code);
        logic [7:0] m;
        unique case (code)
            3'd0: m = {2'd3, 2'd2, 2'd1, 2'd0};
            3'd1: m = {2'd2, 2'd3, 2'd0, 2'd1};
            3'd2: m = {2'd1, 2'd2, 2'd3, 2'd0};
            3'd3: m = {2'd2, 2'd1, 2'd0, 2'd3};
            3'd4: m = {2'd1, 2'd0, 2'd3, 2'd2};
            3'd5: m = {2'd0, 2'd1, 2'd2, 2'd3};
            3'd6: m = {2'd3, 2'd0, 2'd1, 2'd2};
            default: m = {2'd0, 2'd3, 2'd2, 2'd1};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ycc_order_decode.sv
module ycc_order_decode #(
    parameter int BYTE_W = 8
) (
    input  logic [4*BYTE_W-1:0]       word_in,
    input  logic [2:0]                code,
    input  logic                      swap,
    output logic [3:0][BYTE_W-1:0]    comp_out
);
    import ycc_pkg::*;

    localparam int NSLOT = 4;

    logic [NSLOT-1:0][BYTE_W-1:0] raw;
    logic [NSLOT-1:0][BYTE_W-1:0] slot;
    logic [7:0]                   map;

    assign raw = word_in;
    assign map = slot_map(code);

    genvar i;
    generate
        for (i = 0; i < NSLOT; i++) begin : g_swap
            assign slot[i] = swap ? raw[NSLOT-1-i] : raw[i];
        end
        for (i = 0; i < NSLOT; i++) begin : g_pick
            assign comp_out[i] = slot[map[2*i +: 2]];
        end
    endgenerate

endmodule

// File: rtl/ycc_byte_fsm.sv
module ycc_byte_fsm #(
    parameter int              BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] BLANK_C = 8'h80,
    parameter logic [BYTE_W-1:0] BLANK_Y = 8'h10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   in_valid,
    input  logic [3:0][BYTE_W-1:0] comp_in,
    output logic                   in_ready,
    output logic [BYTE_W-1:0]      out_byte,
    output logic                   out_valid,
    output logic                   underrun
);
    import ycc_pkg::*;

    ser_state_t               state, state_nx;
    logic [3:0][BYTE_W-1:0]   held;
    logic                     uflag;
    logic                     take;

    // Boundary: idle or last byte of a word.
    assign in_ready = enable && ((state == S_IDLE) || (state == S_Y1));
    assign take     = in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = enable ? S_CB : S_IDLE;
            S_CB:    state_nx = S_Y0;
            S_Y0:    state_nx = S_CR;
            S_CR:    state_nx = S_Y1;
            S_Y1:    state_nx = enable ? S_CB : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= '0;
            uflag <= 1'b0;
        end else begin
            uflag <= 1'b0;
            if (take) begin
                if (in_valid) begin
                    held <= comp_in;
                end else begin
                    held[COMP_CB] <= BLANK_C;
                    held[COMP_Y0] <= BLANK_Y;
                    held[COMP_CR] <= BLANK_C;
                    held[COMP_Y1] <= BLANK_Y;
                    uflag         <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        out_byte  = '0;
        out_valid = 1'b1;
        unique case (state)
            S_CB:    out_byte = held[COMP_CB];
            S_Y0:    out_byte = held[COMP_Y0];
            S_CR:    out_byte = held[COMP_CR];
            S_Y1:    out_byte = held[COMP_Y1];
            default: out_valid = 1'b0;
        endcase
    end
    assign underrun = uflag;

    assert_step_cb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CB) |=> (state == S_Y0));
    assert_step_y0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Y0) |=> (state == S_CR));
    assert_step_cr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CR) |=> (state == S_Y1));
    assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (state == S_CB && !underrun));
    assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CB || state == S_Y0 || state == S_CR) |=> $stable(held));
    assert_underrun_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);
    assert_underrun_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (out_valid && out_byte == BLANK_C && held[COMP_Y0] == BLANK_Y));
    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_Y1 && !enable) |=> !out_valid);

endmodule

// File: rtl/ycc422_serializer.sv
module ycc422_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [2:0]          ord_code,
    input  logic                big_endian,
    input  logic [4*BYTE_W-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [BYTE_W-1:0]   out_byte,
    output logic                out_valid,
    output logic                underrun
);
    localparam logic [BYTE_W-1:0] BLANK_C = BYTE_W'(8'h80);
    localparam logic [BYTE_W-1:0] BLANK_Y = BYTE_W'(8'h10);

    logic [3:0][BYTE_W-1:0] comp;

    ycc_order_decode #(.BYTE_W(BYTE_W)) u_dec (
        .word_in  (in_data),
        .code     (ord_code),
        .swap     (big_endian),
        .comp_out (comp)
    );

    ycc_byte_fsm #(.BYTE_W(BYTE_W), .BLANK_C(BLANK_C), .BLANK_Y(BLANK_Y)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .in_valid  (in_valid),
        .comp_in   (comp),
        .in_ready  (in_ready),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .underrun  (underrun)
    );

endmodule

// File: tb/tb_ycc422_serializer.sv
module tb_ycc422_serializer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [2:0]  ord_code;
    logic        big_endian;
    logic [31:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        underrun;

    int n_chk = 0;
    int n_bad = 0;
    int wcnt  = 0;
    int cur_code = 0;
    bit cur_be   = 1'b0;
    string phase = "R2";
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    ycc422_serializer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ord_code(ord_code),
        .big_endian(big_endian), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_byte(out_byte), .out_valid(out_valid),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Returns {Cb,Y0,Cr,Y1}.
    function automatic logic [31:0] ref_out(input logic [31:0] w, input int code, input bit be);
        string tbl[8] = '{"BYRZ", "YBZR", "RYBZ", "ZBYR", "RZBY", "ZRYB", "BZRY", "YRZB"};
        logic [7:0] sl[4];
        logic [7:0] cb, y0, cr, y1;
        cb = 0; y0 = 0; cr = 0; y1 = 0;
        for (int i = 0; i < 4; i++)
            sl[i] = be ? w[8*i +: 8] : w[31-8*i -: 8];
        for (int i = 0; i < 4; i++) begin
            if (tbl[code][i] == "B") cb = sl[i];
            if (tbl[code][i] == "Y") y0 = sl[i];
            if (tbl[code][i] == "R") cr = sl[i];
            if (tbl[code][i] == "Z") y1 = sl[i];
        end
        return {cb, y0, cr, y1};
    endfunction

    function automatic logic [31:0] make_word(input int n);
        logic [7:0] b = 8'(4 * n);
        return {b ^ 8'hA5, (b + 8'd1) ^ 8'hA5, (b + 8'd2) ^ 8'hA5, (b + 8'd3) ^ 8'hA5};
    endfunction

    task automatic step(input bit en, input bit give);
        logic [8:0]  e;
        logic [31:0] w, r;
        @(negedge clk);
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected byte", out_byte, 0);
            end else begin
                e = exp_q.pop_front();
                check(out_byte == e[7:0], phase, out_byte, e[7:0]);
                check(underrun == e[8], "R7 underrun flag", underrun, e[8]);
            end
        end else begin
            check(exp_q.size() == 0, "R4/R8 out_valid", 0, 1);
            check(!underrun, "R7 flag while idle", underrun, 0);
        end
        enable = en;
        #1;
        check(in_ready == (en && exp_q.size() == 0), "R5 in_ready", in_ready, en && exp_q.size() == 0);
        if (in_ready) begin
            if (give) begin
                w = make_word(wcnt);
                wcnt++;
                in_data = w; ord_code = 3'(cur_code); big_endian = cur_be; in_valid = 1'b1;
                r = ref_out(w, cur_code, cur_be);
                exp_q.push_back({1'b0, r[31:24]});
                exp_q.push_back({1'b0, r[23:16]});
                exp_q.push_back({1'b0, r[15:8]});
                exp_q.push_back({1'b0, r[7:0]});
            end else begin
                in_valid = 1'b0;
                exp_q.push_back(9'h180);
                exp_q.push_back(9'h010);
                exp_q.push_back(9'h080);
                exp_q.push_back(9'h010);
            end
        end else begin
            // R6: scramble sampled inputs between word boundaries
            in_valid   = 1'b0;
            in_data    = ~make_word(wcnt + 7);
            ord_code   = 3'(cur_code + 5);
            big_endian = ~cur_be;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; ord_code = 3'd0; big_endian = 1'b0;
        in_data = '0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(!underrun, "R1 underrun", underrun, 0);
        check(!in_ready, "R1 in_ready", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !in_ready, "R1 after release", out_valid, 0);

        // R2 and R3: every layout code with both byte orders
        for (int be = 0; be < 2; be++) begin
            for (int c = 0; c < 8; c++) begin
                cur_code = c; cur_be = bit'(be);
                phase = be ? "R3 swapped layout byte" : "R2 layout byte";
                repeat (12) step(1'b1, 1'b1);
            end
        end

        // R7: two missing words back to back, then recovery
        phase = "R7 blank byte";
        cur_code = 3; cur_be = 1'b0;
        repeat (8) step(1'b1, 1'b0);
        phase = "R4 byte after underrun";
        repeat (4) step(1'b1, 1'b1);

        // R8: enable dropped mid-word, then at a boundary
        phase = "R8 byte with enable low";
        cur_code = 6; cur_be = 1'b1;
        step(1'b1, 1'b1);
        repeat (3) step(1'b0, 1'b1);
        repeat (4) step(1'b0, 1'b0);
        phase = "R4 restart byte";
        cur_code = 1; cur_be = 1'b0;
        repeat (8) step(1'b1, 1'b1);
        repeat (6) step(1'b0, 1'b0);
        check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule